// File: doc/BRIEF.md
# Receive Word Boundary Aligner

The aligner sits behind a deserializer and recovers word boundaries in its parallel stream. Each clock it joins the previous and the current input word into a window twice the word width and compares a programmable pattern against every bit offset of that window at once. The word at the chosen offset is registered onto the output. The word width is a parameter, intended for 10 or 20 bits.

A 2-bit mode input picks one of three behaviours at run time. In manual mode a rising edge on the align enable starts a search, and the block locks to the first boundary it finds. In bit-slip mode each request edge moves the boundary by one bit, and no pattern matching takes place. In deterministic-latency mode the data is never re-muxed: the block finds the boundary, then hands the offset to the deserializer through a valid/acknowledge pair, so the deserializer can clock-slip by that many serial bits. A parameter arms one manual search straight out of reset. By default it is on for the 20-bit width only.

Top module: `word_align`

## Requirements
- R1: While rst_ni is low and right after it, sync_o is 0, slip_vld_o is 0 and data_o is all zeros.
- R2: Let P be the previous input word and C the current one. Candidate k (0..W-1) is bits k..k+W-1 of the window {C, P}, with bit 0 the earliest received. The word for offset k appears on data_o one clock after C is presented. On a lock, sync_o rises in that same clock, and data_o already carries the pattern in its low bits. After a lock, data_o keeps following the stream at the locked offset.
- R3: mode_i = 0 selects manual mode. Once locked, the offset and sync_o hold while later pattern occurrences at other offsets pass by, until align_en_i rises again.
- R4: In manual mode a rising edge of align_en_i clears sync_o at the next clock and arms one search. Keeping align_en_i high does not re-arm the search.
- R5: pat_len_i selects how many least significant bits of pat_i and of each candidate are compared: 0 compares 7 bits, 1 compares 10 bits and 2 compares 20 bits (legal only when W = 20).
- R6: When several offsets match in the same clock, the lowest offset is taken.
- R7: With AUTO_FIRST set (default when W = 20), a manual search is armed when reset is released, with no edge on align_en_i needed.
- R8: mode_i = 1 selects bit-slip mode. Each rising edge of slip_req_i adds one to the offset, wrapping from W-1 to 0. The new offset applies to data_o from the following clock, and sync_o clears. Holding the request high slips only once, and sync_o never rises in this mode.
- R9: mode_i = 2 selects deterministic-latency mode, and data_o always equals the previous input word (offset 0). A rising edge of align_en_i arms a search. A match at a nonzero offset k drives slip_cnt_o = k with slip_vld_o = 1. Both hold until a clock where slip_ack_i is high, after which slip_vld_o drops.
- R10: In deterministic-latency mode, matches are ignored while slip_vld_o is high. After the acknowledge the search stays armed. A match at offset 0 then raises sync_o, ends the search and raises no new slip_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Raw word from the deserializer, bit 0 earliest |
| mode_i | input | 2 | 0 manual, 1 bit-slip, 2 deterministic latency |
| pat_i | input | W | Alignment pattern, LSB aligned |
| pat_len_i | input | 2 | Compared length: 0 = 7, 1 = 10, 2 = 20 bits |
| align_en_i | input | 1 | Search request, acted on at its rising edge |
| slip_req_i | input | 1 | Bit-slip request, acted on at its rising edge |
| slip_ack_i | input | 1 | Deserializer accepts the reported slip count |
| data_o | output | W | Aligned word |
| sync_o | output | 1 | Boundary locked |
| slip_vld_o | output | 1 | Slip count valid, held until acknowledged |
| slip_cnt_o | output | $clog2(W) | Serial bits the deserializer must slip |

## Verification
The assertions assume that pat_i, pat_len_i and mode_i stay constant while a search or lock is in progress. They also assume that pat_len_i never selects 20 bits in a 10-bit build, and that slip_ack_i is only raised while slip_vld_o is high. The stimulus changes mode and pattern settings only between scenarios, after the previous lock or report has settled. It raises the acknowledge only against a pending count. The filler around each pattern is zero, and every pattern has its first and last compared bits set, so no stray offset of the filler or of a shifted pattern can match. This keeps each expected lock offset unique.

// File: rtl/word_align_pkg.sv
package word_align_pkg;
  typedef enum logic [1:0] {
    WA_MANUAL  = 2'd0,
    WA_BITSLIP = 2'd1,
    WA_DETLAT  = 2'd2
  } wa_mode_e;

  typedef enum logic [1:0] {
    WA_LEN7  = 2'd0,
    WA_LEN10 = 2'd1,
    WA_LEN20 = 2'd2
  } wa_len_e;

  function automatic int unsigned wa_len_bits(input logic [1:0] code);
    case (wa_len_e'(code))
      WA_LEN7:  return 7;
      WA_LEN10: return 10;
      default:  return 20;
    endcase
  endfunction
endpackage

// File: rtl/word_align_match.sv
module word_align_match #(
  parameter int unsigned W  = 10,
  parameter int unsigned OW = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*W-1:0]  win_i,
  input  logic [W-1:0]    pat_i,
  input  logic [1:0]      len_i,
  output logic            hit_o,
  output logic [OW-1:0]   off_o
);
  import word_align_pkg::*;

  logic [W-1:0] mask;
  logic [W-1:0] match;

  always_comb begin
    for (int i = 0; i < int'(W); i++) mask[i] = (unsigned'(i) < wa_len_bits(len_i));
  end

  for (genvar k = 0; k < int'(W); k++) begin : g_cmp
    assign match[k] = (((win_i[k +: W] ^ pat_i) & mask) == '0);
  end

  // lowest offset wins
  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    for (int k = int'(W) - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o = 1'b1;
        off_o = OW'(k);
      end
    end
  end

  AST_HIT_IS_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match[off_o] && ((match & ((W'(1) << off_o) - W'(1))) == '0))); // R6
  AST_NO_HIT_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match == '0)); // R2
endmodule

// File: rtl/word_align_shift.sv
module word_align_shift #(
  parameter int unsigned W  = 10,
  parameter int unsigned OW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] win_i,
  input  logic [OW-1:0]  sel_i,
  output logic [W-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= win_i[sel_i +: W];
  end
endmodule

// File: rtl/word_align_ctrl.sv
module word_align_ctrl #(
  parameter int unsigned W          = 10,
  parameter int unsigned OW         = $clog2(W),
  parameter bit          AUTO_FIRST = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          align_en_i,
  input  logic          slip_req_i,
  input  logic          slip_ack_i,
  input  logic          hit_i,
  input  logic [OW-1:0] hit_off_i,
  output logic [OW-1:0] sel_o,
  output logic          sync_o,
  output logic          slip_vld_o,
  output logic [OW-1:0] slip_cnt_o
);
  import word_align_pkg::*;

  wa_mode_e      mode;
  logic          en_q, sr_q, armed_q;
  logic [OW-1:0] off_q, off_inc;
  logic          en_rise, slip_rise;

  assign mode      = wa_mode_e'(mode_i);
  assign en_rise   = align_en_i & ~en_q;
  assign slip_rise = slip_req_i & ~sr_q;
  assign off_inc   = (off_q == OW'(W - 1)) ? '0 : off_q + 1'b1;

  // bypass the found offset so data and sync leave on the same edge
  always_comb begin
    if (mode == WA_DETLAT)                                     sel_o = '0;
    else if (mode == WA_MANUAL && armed_q && hit_i && !en_rise) sel_o = hit_off_i;
    else                                                       sel_o = off_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      sr_q       <= 1'b0;
      armed_q    <= AUTO_FIRST;
      off_q      <= '0;
      sync_o     <= 1'b0;
      slip_vld_o <= 1'b0;
      slip_cnt_o <= '0;
    end else begin
      en_q <= align_en_i;
      sr_q <= slip_req_i;
      if (slip_vld_o && slip_ack_i) slip_vld_o <= 1'b0;
      case (mode)
        WA_MANUAL: begin
          if (en_rise) begin
            armed_q <= 1'b1;
            sync_o  <= 1'b0;
          end else if (armed_q && hit_i) begin
            off_q   <= hit_off_i;
            armed_q <= 1'b0;
            sync_o  <= 1'b1;
          end
        end
        WA_BITSLIP: begin
          if (slip_rise) begin
            off_q  <= off_inc;
            sync_o <= 1'b0;
          end
        end
        WA_DETLAT: begin
          if (en_rise) begin
            armed_q <= 1'b1;
            sync_o  <= 1'b0;
          end else if (armed_q && hit_i && !slip_vld_o) begin
            if (hit_off_i == '0) begin
              sync_o  <= 1'b1;
              armed_q <= 1'b0;
            end else begin
              slip_cnt_o <= hit_off_i;
              slip_vld_o <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_o) < W); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WA_MANUAL && sync_o && !en_rise) |=> $stable(off_q)); // R3
  AST_REARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WA_MANUAL && en_rise) |=> !sync_o); // R4
  AST_SLIP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WA_BITSLIP && !slip_rise) |=> $stable(off_q)); // R8
  AST_SLIP_NO_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WA_BITSLIP && !sync_o) |=> !sync_o); // R8
  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_vld_o && !slip_ack_i) |=> (slip_vld_o && $stable(slip_cnt_o))); // R9
  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_vld_o |-> (slip_cnt_o != '0)); // R10
endmodule

// File: rtl/word_align.sv
module word_align #(
  parameter int unsigned W          = 10,
  parameter bit          AUTO_FIRST = (W == 20)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [W-1:0]           data_i,
  input  logic [1:0]             mode_i,
  input  logic [W-1:0]           pat_i,
  input  logic [1:0]             pat_len_i,
  input  logic                   align_en_i,
  input  logic                   slip_req_i,
  input  logic                   slip_ack_i,
  output logic [W-1:0]           data_o,
  output logic                   sync_o,
  output logic                   slip_vld_o,
  output logic [$clog2(W)-1:0]   slip_cnt_o
);
  import word_align_pkg::*;

  localparam int unsigned OW = $clog2(W);

  logic [W-1:0]   prev_q;
  logic [2*W-1:0] win;
  logic           hit;
  logic [OW-1:0]  hit_off, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  assign win = {data_i, prev_q};

  word_align_match #(.W(W), .OW(OW)) u_match (
    .clk_i (clk_i), .rst_ni (rst_ni), .win_i (win), .pat_i (pat_i),
    .len_i (pat_len_i), .hit_o (hit), .off_o (hit_off)
  );

  word_align_ctrl #(.W(W), .OW(OW), .AUTO_FIRST(AUTO_FIRST)) u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
    .align_en_i (align_en_i), .slip_req_i (slip_req_i), .slip_ack_i (slip_ack_i),
    .hit_i (hit), .hit_off_i (hit_off), .sel_o (sel),
    .sync_o (sync_o), .slip_vld_o (slip_vld_o), .slip_cnt_o (slip_cnt_o)
  );

  word_align_shift #(.W(W), .OW(OW)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .win_i (win), .sel_i (sel), .data_o (data_o)
  );

  logic [W-1:0] cmp_mask;
  always_comb begin
    for (int i = 0; i < int'(W); i++) cmp_mask[i] = (unsigned'(i) < wa_len_bits(pat_len_i));
  end

  AST_SYNC_CARRIES_PAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (((data_o ^ pat_i) & cmp_mask) == '0)); // R2
  AST_DL_UNSHIFTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_mode_e'(mode_i) == WA_DETLAT) |=> (data_o == $past(prev_q))); // R9
endmodule

// File: tb/word_align_tb_top.sv
module word_align_tb_top;
  localparam int W          = 20;
  localparam int OW         = $clog2(W);
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 200;
  localparam logic [W-1:0] PAT20 = 20'hC0301;
  localparam logic [W-1:0] PAT10 = 20'h00305;
  localparam logic [W-1:0] PAT7  = 20'h00059;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [1:0]    mode_i = 2'd0;
  logic [W-1:0]  pat_i = PAT20;
  logic [1:0]    pat_len_i = 2'd2;
  logic          align_en_i = 1'b0;
  logic          slip_req_i = 1'b0;
  logic          slip_ack_i = 1'b0;
  logic [W-1:0]  data_o;
  logic          sync_o;
  logic          slip_vld_o;
  logic [OW-1:0] slip_cnt_o;

  logic [W*NWORDS-1:0] strm = '0;
  int wi = 0;
  int last = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  word_align #(.W(W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .mode_i (mode_i),
    .pat_i (pat_i), .pat_len_i (pat_len_i), .align_en_i (align_en_i),
    .slip_req_i (slip_req_i), .slip_ack_i (slip_ack_i), .data_o (data_o),
    .sync_o (sync_o), .slip_vld_o (slip_vld_o), .slip_cnt_o (slip_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    data_i = strm[wi*W +: W];
    last = wi;
    wi++;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [W-1:0] expw(input int off);
    return strm[(last-1)*W + off +: W];
  endfunction

  task automatic place(input int word, input int off, input logic [W-1:0] pat, input int len);
    for (int b = 0; b < len; b++) strm[word*W + off + b] = pat[b];
  endtask

  // steps until the word after 'word' is presented; sync must stay low before
  task automatic expect_lock(input int word, input int off, input logic [W-1:0] pat, input int len, input string req);
    logic [W-1:0] m;
    m = W'((64'(1) << len) - 1);
    while (last < word + 1) begin
      step();
      if (last < word + 1) chk(sync_o == 1'b0, {req, " early sync"}, W'(sync_o), '0);
    end
    chk(sync_o == 1'b1, {req, " sync at lock"}, W'(sync_o), W'(1));
    chk((data_o & m) == (pat & m), {req, " pattern at boundary"}, data_o & m, pat & m);
    chk(data_o == expw(off), {req, " aligned word"}, data_o, expw(off));
  endtask

  task automatic follow(input int n, input int off, input logic s, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      chk(data_o == expw(off), {req, " data follows offset"}, data_o, expw(off));
      chk(sync_o == s, {req, " sync level"}, W'(sync_o), W'(s));
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) step();
    chk(sync_o == 1'b0, "R1 sync", W'(sync_o), '0);
    chk(slip_vld_o == 1'b0, "R1 valid", W'(slip_vld_o), '0);
    chk(data_o == '0, "R1 data", data_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk(sync_o == 1'b0 && slip_vld_o == 1'b0, "R1 after release", W'({sync_o, slip_vld_o}), '0);
  endtask

  task automatic t_auto_first();
    int w;
    w = wi + 2;
    place(w, 7, PAT20, 20);
    expect_lock(w, 7, PAT20, 20, "R7 auto first lock R5 len20");
    follow(3, 7, 1'b1, "R2 locked stream");
  endtask

  task automatic t_oneshot();
    int w;
    w = wi + 1;
    place(w, 3, PAT20, 20);
    follow(5, 7, 1'b1, "R3 later pattern ignored");
  endtask

  task automatic t_rearm();
    int w;
    pat_len_i = 2'd1;
    pat_i = PAT10;
    align_en_i = 1'b1;
    step();
    chk(sync_o == 1'b0, "R4 rise clears sync", W'(sync_o), '0);
    w = wi + 1;
    place(w, 12, PAT10, 10);
    expect_lock(w, 12, PAT10, 10, "R4 rearmed lock R5 len10");
    w = wi + 1;
    place(w, 5, PAT10, 10);
    follow(4, 12, 1'b1, "R4 held enable no rearm");
    align_en_i = 1'b0;
    step();
  endtask

  task automatic t_short_lowest();
    int w;
    pat_len_i = 2'd0;
    pat_i = PAT7;
    align_en_i = 1'b1;
    step();
    align_en_i = 1'b0;
    w = wi + 1;
    place(w, 4, PAT7, 7);
    place(w, 12, PAT7, 7);
    expect_lock(w, 4, PAT7, 7, "R6 lowest offset R5 len7");
    follow(2, 4, 1'b1, "R6 stays at lowest");
  endtask

  task automatic t_bitslip();
    int off;
    off = 4;
    mode_i = 2'd1;
    slip_req_i = 1'b1;
    step();
    chk(sync_o == 1'b0, "R8 slip clears sync", W'(sync_o), '0);
    chk(data_o == expw(off), "R8 old offset on request edge", data_o, expw(off));
    off = 5;
    step();
    chk(data_o == expw(off), "R8 held request slips once", data_o, expw(off));
    slip_req_i = 1'b0;
    place(wi + 1, 5, PAT7, 7);
    follow(3, off, 1'b0, "R8 no matching in bit-slip");
    for (int i = 0; i < 14; i++) begin
      slip_req_i = 1'b1;
      step();
      slip_req_i = 1'b0;
      off++;
      step();
      chk(data_o == expw(off), "R8 one bit per request", data_o, expw(off));
    end
    slip_req_i = 1'b1;
    step();
    slip_req_i = 1'b0;
    step();
    chk(data_o == expw(0), "R8 wrap to zero", data_o, expw(0));
    follow(2, 0, 1'b0, "R8 after wrap");
  endtask

  task automatic t_detlat();
    int w;
    mode_i = 2'd2;
    pat_len_i = 2'd2;
    pat_i = PAT20;
    align_en_i = 1'b1;
    step();
    chk(slip_vld_o == 1'b0, "R9 no report on arm", W'(slip_vld_o), '0);
    chk(data_o == expw(0), "R9 unshifted data", data_o, expw(0));
    w = wi + 1;
    place(w, 9, PAT20, 20);
    while (last < w + 1) begin
      step();
      if (last < w + 1) chk(slip_vld_o == 1'b0, "R9 early report", W'(slip_vld_o), '0);
    end
    chk(slip_vld_o == 1'b1, "R9 report valid", W'(slip_vld_o), W'(1));
    chk(slip_cnt_o == OW'(9), "R9 slip count", W'(slip_cnt_o), W'(9));
    chk(data_o == expw(0), "R9 data not shifted", data_o, expw(0));
    chk(sync_o == 1'b0, "R9 no sync before slip", W'(sync_o), '0);
    w = wi + 1;
    place(w, 3, PAT20, 20);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(slip_vld_o == 1'b1 && slip_cnt_o == OW'(9), "R10 pending count held",
          W'(slip_cnt_o), W'(9));
    end
    slip_ack_i = 1'b1;
    step();
    slip_ack_i = 1'b0;
    chk(slip_vld_o == 1'b0, "R9 ack drops valid", W'(slip_vld_o), '0);
    w = wi + 1;
    place(w, 0, PAT20, 20);
    expect_lock(w, 0, PAT20, 20, "R10 zero offset sync");
    chk(slip_vld_o == 1'b0, "R10 no report at offset zero", W'(slip_vld_o), '0);
    align_en_i = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_auto_first();
    t_oneshot();
    t_rearm();
    t_short_lowest();
    t_bitslip();
    t_detlat();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule